// File: doc/BRIEF.md
# Codec Link Input Frame Decoder

This block sits in an audio controller on the receive side of a serial codec link. The codec drives a bit clock, a frame sync and one serial data line. The decoder runs on the controller's system clock and samples those three lines. It finds each falling edge of the bit clock and takes one data bit there. The rising edge of frame sync starts a new frame. The frame is a 16-bit tag slot followed by twelve 20-bit slots, each sent most significant bit first.

From the tag slot the decoder takes the codec-ready bit and the valid marks for slots 1 to 4. Slot 1 gives the echoed register index and six active-low flags. The flags tell the output-frame builder which playback slots it has to fill in the next frame. Slot 2 returns status data for a register read. The decoder reports it only when the echoed index matches a read the controller issued earlier. A one-deep pending-read register holds that read. The decoder takes the left and right record samples from slots 3 and 4. It presents both samples together with a one-cycle strobe.

Top module: `codec_in_frame_dec`

## Requirements
- R1: Data is sampled on each falling edge of `bclk`. A rising `fsync` seen at a sampled edge makes that bit the first tag bit and restarts counting, even in the middle of a frame. Counting then runs 16 tag bits, then twelve 20-bit slots, MSB first.
- R2: When a tag slot completes, `codec_ready` takes tag bit 15. Tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4 valid. When `codec_ready` is 0, no field output changes and no strobe is raised for that frame.
- R3: When slot 1 is valid, `echo_idx` takes slot 1 bits 18:12. Bit 19 has no effect.
- R4: When slot 1 is valid, `slot_need[5:0]` takes the inverse of slot 1 bits 11, 10, 8, 7, 6 and 5, in that order. These bits are the requests for playback slots 3, 4, 6, 7, 8 and 9, so a 1 on `slot_need` means the slot must be sent. Slot 1 bits 9 and 4:0 have no effect.
- R5: A `rd_req` pulse loads `rd_addr` into the pending register. Suppose slots 1 and 2 are valid and a read is pending whose address equals the echoed index. Then, at the end of slot 2, `stat_data` takes slot 2 bits 19:4 and `stat_idx` takes the index, `stat_vld` pulses, and the pending read is cleared. Slot 2 bits 3:0 have no effect.
- R6: With no read pending, or with an echoed index that differs from the pending address, `stat_vld` stays low and `stat_data` keeps its value. A mismatch leaves the pending read in place.
- R7: When slots 3 and 4 are both valid, `pcm_left` takes slot 3 bits 19:2 and `pcm_right` takes slot 4 bits 19:2, at the end of slot 4, and `pcm_vld` pulses. Bits 1:0 have no effect. If either slot is invalid, neither sample changes.
- R8: The contents of slots 5 to 12 have no effect on any output.
- R9: After reset all outputs are zero and no read is pending.
- R10: `stat_vld` and `pcm_vld` are single-cycle pulses, at most one per frame each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Link bit clock, sampled on `clk` |
| fsync | input | 1 | Frame sync, sampled on falling `bclk` |
| sdin | input | 1 | Serial input data, sampled on falling `bclk` |
| rd_req | input | 1 | Controller issued a register read (one-cycle pulse) |
| rd_addr | input | 7 | Address of the issued read |
| codec_ready | output | 1 | Ready bit of the last tag slot |
| echo_idx | output | 7 | Register index echoed in slot 1 |
| slot_need | output | 6 | Playback slots 3,4,6,7,8,9 to send next frame (1 = send) |
| stat_vld | output | 1 | Status word returned for the pending read |
| stat_idx | output | 7 | Index of the returned status word |
| stat_data | output | 16 | Returned status word |
| pcm_vld | output | 1 | New record sample pair |
| pcm_left | output | 18 | Left record sample |
| pcm_right | output | 18 | Right record sample |

## Verification
The bit taken at a falling edge of `bclk` passes through three registers: the edge sampler, the slot counter and the output stage. So every field output and strobe appears three `clk` cycles after the cycle in which that slot's last bit edge was seen. The bench runs one bit every eight `clk` cycles and feeds whole frames. It reads held outputs only after the frame has ended, well past that three-cycle delay. A monitor samples on the falling `clk` edge and counts the strobes, and flags any strobe that lasts two cycles. Each scenario then compares those counts with the number of pulses its requirement allows.

// File: rtl/cl_pkg.sv
package cl_pkg;

    // number of playback slots whose request flag is carried in slot 1
    localparam int REQ_N = 6;

    // bit position in slot 1 of request flag i (playback slots 3,4,6,7,8,9)
    function automatic int req_pos(input int i);
        case (i)
            0:       return 11;
            1:       return 10;
            2:       return 8;
            3:       return 7;
            4:       return 6;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/cl_bit_sampler.sv
module cl_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic sdin,
    output logic bit_stb,
    output logic bit_val,
    output logic frm_start
);
    typedef struct packed {
        logic bclk_p;
        logic sync_p;
        logic stb;
        logic val;
        logic start;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.bclk_p = bclk;
        s_d.stb    = s_q.bclk_p & ~bclk;
        s_d.start  = 1'b0;
        if (s_q.bclk_p && !bclk) begin
            s_d.val    = sdin;
            s_d.start  = fsync & ~s_q.sync_p;
            s_d.sync_p = fsync;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_stb   = s_q.stb;
    assign bit_val   = s_q.val;
    assign frm_start = s_q.start;
endmodule

// File: rtl/cl_slot_ctr.sv
module cl_slot_ctr #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    localparam int SCW   = $clog2(NSLOT + 1),
    localparam int BCW   = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              frm_start,
    output logic              word_stb,
    output logic [SLOT_W-1:0] word,
    output logic [SCW-1:0]    word_slot
);
    localparam logic [BCW-1:0] TAG_LAST  = BCW'(TAG_W - 1);
    localparam logic [BCW-1:0] SLOT_LAST = BCW'(SLOT_W - 1);
    localparam logic [SCW-1:0] SLOT_END  = SCW'(NSLOT);

    typedef struct packed {
        logic              active;
        logic [SCW-1:0]    slot;
        logic [BCW-1:0]    bitn;
        logic [SLOT_W-1:0] shreg;
        logic              wstb;
        logic [SLOT_W-1:0] wdat;
        logic [SCW-1:0]    wslot;
    } ctr_t;

    ctr_t c_d, c_q;
    logic              act_c;
    logic [SCW-1:0]    slot_c;
    logic [BCW-1:0]    bit_c;
    logic [SLOT_W-1:0] w_c;
    logic              last_c;

    always_comb begin
        c_d      = c_q;
        c_d.wstb = 1'b0;
        act_c    = c_q.active;
        slot_c   = c_q.slot;
        bit_c    = c_q.bitn;
        if (frm_start) begin
            act_c  = 1'b1;
            slot_c = '0;
            bit_c  = '0;
        end
        w_c    = {c_q.shreg[SLOT_W-2:0], bit_val};
        last_c = act_c && ((slot_c == '0) ? (bit_c == TAG_LAST) : (bit_c == SLOT_LAST));
        if (bit_stb) begin
            c_d.shreg  = w_c;
            c_d.active = act_c;
            c_d.slot   = slot_c;
            c_d.bitn   = bit_c;
            if (act_c) begin
                if (last_c) begin
                    c_d.wstb  = 1'b1;
                    c_d.wdat  = w_c;
                    c_d.wslot = slot_c;
                    c_d.bitn  = '0;
                    c_d.slot  = slot_c + 1'b1;
                    if (slot_c == SLOT_END) c_d.active = 1'b0;
                end else begin
                    c_d.bitn = bit_c + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign word_stb  = c_q.wstb;
    assign word      = c_q.wdat;
    assign word_slot = c_q.wslot;
endmodule

// File: rtl/cl_pend_rd.sv
module cl_pend_rd #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_addr,
    input  logic             clr,
    output logic             pend_vld,
    output logic [IDX_W-1:0] pend_addr
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] addr;
    } pend_t;

    pend_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (rd_req) begin
            p_d.vld  = 1'b1;
            p_d.addr = rd_addr;
        end else if (clr) begin
            p_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pend_vld  = p_q.vld;
    assign pend_addr = p_q.addr;
endmodule

// File: rtl/codec_in_frame_dec.sv
module codec_in_frame_dec #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int IDX_W  = 7,
    parameter int STAT_W = 16,
    parameter int PCM_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk,
    input  logic                     fsync,
    input  logic                     sdin,
    input  logic                     rd_req,
    input  logic [IDX_W-1:0]         rd_addr,
    output logic                     codec_ready,
    output logic [IDX_W-1:0]         echo_idx,
    output logic [cl_pkg::REQ_N-1:0] slot_need,
    output logic                     stat_vld,
    output logic [IDX_W-1:0]         stat_idx,
    output logic [STAT_W-1:0]        stat_data,
    output logic                     pcm_vld,
    output logic [PCM_W-1:0]         pcm_left,
    output logic [PCM_W-1:0]         pcm_right
);
    localparam int SCW   = $clog2(NSLOT + 1);
    localparam int REQS  = cl_pkg::REQ_N;
    localparam int PAD_W = SLOT_W - PCM_W;
    localparam logic [SCW-1:0] SL_TAG = SCW'(0);
    localparam logic [SCW-1:0] SL_CMD = SCW'(1);
    localparam logic [SCW-1:0] SL_STA = SCW'(2);
    localparam logic [SCW-1:0] SL_LFT = SCW'(3);
    localparam logic [SCW-1:0] SL_RGT = SCW'(4);

    logic              bit_stb, bit_val, frm_start;
    logic              word_stb;
    logic [SLOT_W-1:0] word;
    logic [SCW-1:0]    word_slot;
    logic              pend_vld;
    logic [IDX_W-1:0]  pend_addr;
    logic              hit;
    logic [REQS-1:0]   req_raw;

    cl_bit_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
        .bit_stb(bit_stb), .bit_val(bit_val), .frm_start(frm_start)
    );

    cl_slot_ctr #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_ctr (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .frm_start(frm_start), .word_stb(word_stb), .word(word), .word_slot(word_slot)
    );

    cl_pend_rd #(.IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .clr(hit), .pend_vld(pend_vld), .pend_addr(pend_addr)
    );

    for (genvar g = 0; g < REQS; g++) begin : g_req
        assign req_raw[g] = word[cl_pkg::req_pos(g)];
    end

    typedef struct packed {
        logic              ready;
        logic [3:0]        svld;   // [3]=slot1 .. [0]=slot4
        logic [IDX_W-1:0]  echo;
        logic [REQS-1:0]   need;
        logic              svld_o;
        logic [IDX_W-1:0]  sidx;
        logic [STAT_W-1:0] sdat;
        logic [PCM_W-1:0]  lstage;
        logic              pvld;
        logic [PCM_W-1:0]  left;
        logic [PCM_W-1:0]  right;
    } dec_t;

    dec_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.svld_o = 1'b0;
        r_d.pvld   = 1'b0;
        hit        = 1'b0;
        if (word_stb) begin
            if (word_slot == SL_TAG) begin
                r_d.ready = word[TAG_W-1];
                r_d.svld  = word[TAG_W-2 -: 4];
            end else if (word_slot == SL_CMD) begin
                if (r_q.ready && r_q.svld[3]) begin
                    r_d.echo = word[SLOT_W-2 -: IDX_W];
                    r_d.need = ~req_raw;
                end
            end else if (word_slot == SL_STA) begin
                if (r_q.ready && r_q.svld[3] && r_q.svld[2] &&
                    pend_vld && (r_q.echo == pend_addr)) begin
                    hit        = 1'b1;
                    r_d.svld_o = 1'b1;
                    r_d.sidx   = r_q.echo;
                    r_d.sdat   = word[SLOT_W-1 -: STAT_W];
                end
            end else if (word_slot == SL_LFT) begin
                if (r_q.ready && r_q.svld[1])
                    r_d.lstage = word[SLOT_W-1 -: PCM_W];
            end else if (word_slot == SL_RGT) begin
                if (r_q.ready && r_q.svld[1] && r_q.svld[0]) begin
                    r_d.left  = r_q.lstage;
                    r_d.right = word[SLOT_W-1 -: PCM_W];
                    r_d.pvld  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    logic unused_bits;
    assign unused_bits = ^{word[PAD_W-1:0], word[TAG_W-6:0]};

    assign codec_ready = r_q.ready;
    assign echo_idx    = r_q.echo;
    assign slot_need   = r_q.need;
    assign stat_vld    = r_q.svld_o;
    assign stat_idx    = r_q.sidx;
    assign stat_data   = r_q.sdat;
    assign pcm_vld     = r_q.pvld;
    assign pcm_left    = r_q.left;
    assign pcm_right   = r_q.right;
endmodule

// File: rtl/cl_dec_chk.sv
module cl_dec_chk #(
    parameter int IDX_W  = 7,
    parameter int STAT_W = 16,
    parameter int PCM_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              pend_vld,
    input logic [IDX_W-1:0]  pend_addr,
    input logic              codec_ready,
    input logic              stat_vld,
    input logic [IDX_W-1:0]  stat_idx,
    input logic [STAT_W-1:0] stat_data,
    input logic              pcm_vld,
    input logic [PCM_W-1:0]  pcm_left,
    input logic [PCM_W-1:0]  pcm_right
);
    AST_STAT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> $past(pend_vld)); // R5
    AST_STAT_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_idx == $past(pend_addr))); // R5
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && !$past(rd_req)) |-> !pend_vld); // R5
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_data) |-> stat_vld); // R6
    AST_PCM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pcm_left) || !$stable(pcm_right)) |-> pcm_vld); // R7
    AST_PCM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_vld |-> codec_ready); // R2
    AST_PCM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_vld |=> !pcm_vld); // R10
    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld); // R10
endmodule

bind codec_in_frame_dec cl_dec_chk #(.IDX_W(IDX_W), .STAT_W(STAT_W), .PCM_W(PCM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .pend_vld(pend_vld),
    .pend_addr(pend_addr), .codec_ready(codec_ready), .stat_vld(stat_vld),
    .stat_idx(stat_idx), .stat_data(stat_data), .pcm_vld(pcm_vld),
    .pcm_left(pcm_left), .pcm_right(pcm_right)
);

// File: tb/sim_codec_in_frame_dec.sv
`timescale 1ns/1ps
module sim_codec_in_frame_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdin = 1'b0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        codec_ready;
    logic [6:0]  echo_idx;
    logic [5:0]  slot_need;
    logic        stat_vld;
    logic [6:0]  stat_idx;
    logic [15:0] stat_data;
    logic        pcm_vld;
    logic [17:0] pcm_left;
    logic [17:0] pcm_right;

    always #4 clk = ~clk;

    codec_in_frame_dec u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
        .rd_req(rd_req), .rd_addr(rd_addr), .codec_ready(codec_ready),
        .echo_idx(echo_idx), .slot_need(slot_need), .stat_vld(stat_vld),
        .stat_idx(stat_idx), .stat_data(stat_data), .pcm_vld(pcm_vld),
        .pcm_left(pcm_left), .pcm_right(pcm_right)
    );

    int checks = 0;
    int fails = 0;
    int pcm_cnt = 0;
    int stat_cnt = 0;
    logic pcm_prev = 1'b0;
    logic stat_prev = 1'b0;
    logic done = 1'b0;

    logic [15:0] ftag;
    logic [19:0] fslot [1:12];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pcm_vld) pcm_cnt++;
            if (stat_vld) stat_cnt++;
            if (pcm_vld && pcm_prev) chk(1'b0, "R10 pcm_vld width", 2, 1);
            if (stat_vld && stat_prev) chk(1'b0, "R10 stat_vld width", 2, 1);
        end
        pcm_prev  = pcm_vld;
        stat_prev = stat_vld;
    end

    function automatic logic [15:0] mk_tag(input bit rdy, input bit v1, input bit v2, input bit v3, input bit v4);
        return {rdy, v1, v2, v3, v4, 11'h0};
    endfunction

    // need bits are active-high: need[0..5] = playback slots 3,4,6,7,8,9
    function automatic logic [19:0] mk_cmd(input logic [6:0] idx, input logic [5:0] need);
        return {1'b0, idx, ~need[0], ~need[1], 1'b0, ~need[2], ~need[3], ~need[4], ~need[5], 5'h0};
    endfunction

    task automatic send_bit(input logic sy, input logic d);
        @(negedge clk);
        bclk = 1'b1; fsync = sy; sdin = d;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            if (i < 16) send_bit(1'b1, ftag[15-i]);
            else        send_bit(1'b0, fslot[(i-16)/20+1][19-((i-16)%20)]);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic clear_frame();
        ftag = '0;
        for (int s = 1; s <= 12; s++) fslot[s] = '0;
    endtask

    task automatic issue_read(input logic [6:0] a);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(codec_ready == 0, "R9 codec_ready", codec_ready, 0);
        chk(echo_idx == 0 && slot_need == 0, "R9 echo/need", {echo_idx, slot_need}, 0);
        chk(stat_vld == 0 && stat_data == 0 && stat_idx == 0, "R9 status", stat_data, 0);
        chk(pcm_vld == 0 && pcm_left == 0 && pcm_right == 0, "R9 pcm", pcm_left, 0);
    endtask

    task automatic t_basic();
        clear_frame();
        ftag = mk_tag(1, 1, 1, 1, 1);
        fslot[1] = mk_cmd(7'h26, 6'b101101);
        fslot[2] = {16'hABCD, 4'h0};
        fslot[3] = {18'h2ABCD, 2'b00};
        fslot[4] = {18'h15432, 2'b00};
        pcm_cnt = 0; stat_cnt = 0;
        send_frame(256);
        chk(codec_ready == 1, "R2 ready bit", codec_ready, 1);
        chk(echo_idx == 7'h26, "R3 echo idx", echo_idx, 7'h26);
        chk(slot_need == 6'b101101, "R4 need flags", slot_need, 6'b101101);
        chk(pcm_left == 18'h2ABCD, "R7 left", pcm_left, 18'h2ABCD);
        chk(pcm_right == 18'h15432, "R7 right", pcm_right, 18'h15432);
        chk(pcm_cnt == 1, "R7 pcm pulse count", pcm_cnt, 1);
        chk(stat_cnt == 0, "R6 no pending, no status", stat_cnt, 0);
        chk(stat_data == 0, "R6 status data kept", stat_data, 0);
    endtask

    task automatic t_read();
        issue_read(7'h26);
        clear_frame();
        ftag = mk_tag(1, 1, 1, 0, 0);
        fslot[1] = mk_cmd(7'h26, 6'b000011);
        fslot[2] = {16'hBEEF, 4'hF};
        stat_cnt = 0; pcm_cnt = 0;
        send_frame(256);
        chk(stat_cnt == 1, "R5 status pulse", stat_cnt, 1);
        chk(stat_data == 16'hBEEF, "R5 status data, low bits ignored", stat_data, 16'hBEEF);
        chk(stat_idx == 7'h26, "R5 status idx", stat_idx, 7'h26);
        chk(pcm_cnt == 0, "R7 slots 3/4 invalid", pcm_cnt, 0);
        chk(pcm_left == 18'h2ABCD, "R7 left kept", pcm_left, 18'h2ABCD);
        // pending cleared: same echo again must not report
        fslot[2] = {16'h1111, 4'h0};
        stat_cnt = 0;
        send_frame(256);
        chk(stat_cnt == 0, "R5 pending cleared after return", stat_cnt, 0);
        chk(stat_data == 16'hBEEF, "R5 data held after clear", stat_data, 16'hBEEF);
    endtask

    task automatic t_mismatch();
        issue_read(7'h1C);
        clear_frame();
        ftag = mk_tag(1, 1, 1, 0, 0);
        fslot[1] = mk_cmd(7'h02, 6'b111111);
        fslot[2] = {16'h1234, 4'h0};
        stat_cnt = 0;
        send_frame(256);
        chk(stat_cnt == 0, "R6 index mismatch", stat_cnt, 0);
        chk(stat_data == 16'hBEEF, "R6 data kept on mismatch", stat_data, 16'hBEEF);
        fslot[1] = mk_cmd(7'h1C, 6'b111111);
        fslot[2] = {16'h5A5A, 4'h0};
        send_frame(256);
        chk(stat_cnt == 1, "R6 pending kept after mismatch", stat_cnt, 1);
        chk(stat_data == 16'h5A5A, "R5 matched data", stat_data, 16'h5A5A);
    endtask

    task automatic t_not_ready();
        issue_read(7'h55);
        clear_frame();
        ftag = mk_tag(0, 1, 1, 1, 1);
        fslot[1] = mk_cmd(7'h55, 6'b000000);
        fslot[2] = {16'h7777, 4'h0};
        fslot[3] = {18'h11111, 2'b00};
        fslot[4] = {18'h22222, 2'b00};
        stat_cnt = 0; pcm_cnt = 0;
        send_frame(256);
        chk(codec_ready == 0, "R2 ready low", codec_ready, 0);
        chk(echo_idx == 7'h1C, "R2 echo unchanged", echo_idx, 7'h1C);
        chk(slot_need == 6'b111111, "R2 need unchanged", slot_need, 6'b111111);
        chk(pcm_cnt == 0 && pcm_left == 18'h2ABCD, "R2 pcm unchanged", pcm_left, 18'h2ABCD);
        chk(stat_cnt == 0 && stat_data == 16'h5A5A, "R2 no status", stat_data, 16'h5A5A);
    endtask

    task automatic t_slot_invalid();
        clear_frame();
        ftag = mk_tag(1, 1, 0, 1, 0);
        fslot[1] = mk_cmd(7'h33, 6'b010101);
        fslot[3] = {18'h3FFFF, 2'b00};
        fslot[4] = {18'h3FFFF, 2'b00};
        pcm_cnt = 0;
        send_frame(256);
        chk(echo_idx == 7'h33, "R3 echo with slot 1 valid", echo_idx, 7'h33);
        chk(pcm_cnt == 0, "R7 slot 4 invalid no pulse", pcm_cnt, 0);
        chk(pcm_left == 18'h2ABCD && pcm_right == 18'h15432, "R7 samples kept", pcm_right, 18'h15432);
        ftag = mk_tag(1, 0, 0, 1, 1);
        fslot[1] = mk_cmd(7'h0F, 6'b000000);
        send_frame(256);
        chk(echo_idx == 7'h33 && slot_need == 6'b010101, "R2 slot 1 invalid ignored", echo_idx, 7'h33);
        chk(pcm_cnt == 1 && pcm_left == 18'h3FFFF, "R7 pair updated", pcm_left, 18'h3FFFF);
    endtask

    task automatic t_reserved();
        clear_frame();
        ftag = mk_tag(1, 1, 1, 1, 1);
        fslot[1] = mk_cmd(7'h44, 6'b010011) | 20'h8021F;
        fslot[2] = {16'h9999, 4'hF};
        fslot[3] = {18'h0A5A5, 2'b11};
        fslot[4] = {18'h35A5A, 2'b11};
        for (int s = 5; s <= 12; s++) fslot[s] = 20'hFFFFF;
        pcm_cnt = 0; stat_cnt = 0;
        send_frame(256);
        chk(echo_idx == 7'h44, "R3 bit 19 ignored", echo_idx, 7'h44);
        chk(slot_need == 6'b010011, "R4 bits 9, 4:0 ignored", slot_need, 6'b010011);
        chk(pcm_left == 18'h0A5A5, "R7 left low bits ignored", pcm_left, 18'h0A5A5);
        chk(pcm_right == 18'h35A5A, "R7 right low bits ignored", pcm_right, 18'h35A5A);
        chk(pcm_cnt == 1, "R8 one pcm pulse", pcm_cnt, 1);
        chk(stat_cnt == 0 && stat_data == 16'h5A5A, "R8 no status from filler", stat_data, 16'h5A5A);
    endtask

    task automatic t_resync();
        clear_frame();
        ftag = mk_tag(1, 1, 1, 1, 1);
        fslot[1] = mk_cmd(7'h7F, 6'b000000);
        pcm_cnt = 0; stat_cnt = 0;
        send_frame(30);
        fslot[1] = mk_cmd(7'h55, 6'b100001);
        fslot[2] = {16'hC0DE, 4'h0};
        fslot[3] = {18'h12345, 2'b00};
        fslot[4] = {18'h23456, 2'b00};
        send_frame(256);
        chk(echo_idx == 7'h55, "R1 resync echo", echo_idx, 7'h55);
        chk(slot_need == 6'b100001, "R1 resync need", slot_need, 6'b100001);
        chk(stat_cnt == 1 && stat_data == 16'hC0DE, "R1 resync status", stat_data, 16'hC0DE);
        chk(pcm_cnt == 1 && pcm_left == 18'h12345 && pcm_right == 18'h23456,
            "R1 resync pcm", pcm_right, 18'h23456);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_basic();
        t_read();
        t_mismatch();
        t_not_ready();
        t_slot_invalid();
        t_reserved();
        t_resync();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule